// File: doc/BRIEF.md
# Byte-Lane SECDED Protected Memory

This block is a small word-wide storage array protected by an error code on each byte lane. Every 32-bit word is split into four lanes. Each lane is stored as its own 13-bit extended Hamming codeword, so a stored word is 52 bits. A read checks each lane separately. One flipped bit in a lane is repaired before the data leaves the block. Two flipped bits in a lane are flagged as uncorrectable. Because the lanes are independent, a word that has one upset in every lane still comes back fully repaired.

Protection can be switched off at run time with `eccOn`. While it is low, reads return the stored data bits untouched and raise no flags. Writes made in that state store the data bits of the enabled lanes and leave those lanes' check bits as they were. Inside the array the 13 bits of the four lanes are interleaved, so that neighbouring bits of one codeword sit in different lanes' columns. Two saturating counters total the corrected lanes and the uncorrectable lanes seen by checked reads, and a clear input zeroes both.

Top module: `byteEccMem`

## Requirements
- R1: After reset, `rdValid` is low and both event counters read zero.
- R2: A read issued with `rdEn` high in one cycle presents `rdValid`, `rdData` and both masks in the following cycle. A lane that is stored clean returns its written byte, with its mask bits clear.
- R3: A write updates only the lanes whose `byteEn` bit is set. Data and check bits of the other lanes are kept, so a later checked read of those lanes is clean.
- R4: With protection on, a single flipped data bit in a lane is repaired, and that lane's bit in `corrMask` is set (bit b of each mask stands for data bits 8b+7..8b).
- R5: Each lane is decoded on its own, so one flipped bit in each of the four lanes gives the original word with `corrMask` equal to 4'hF.
- R6: Two flipped data bits in one lane set that lane's `uncMask` bit, and the lane returns its stored bits unchanged.
- R7: Lane codeword layout: position 0 holds overall parity, positions 1, 2, 4 and 8 hold check bits, and data bits 0..7 sit at positions 3, 5, 6, 7, 9, 10, 11 and 12. A single error in a check or parity position is reported in `corrMask`, and the stored data byte is returned as is. One way to bring this about is to overwrite data bits 0, 1 and 3 of a lane without updating its checks, which leaves the lane one bit away from the codeword of the new data at position 1.
- R8: A read issued with `eccOn` low returns the stored data bits, keeps both masks zero and leaves both counters unchanged.
- R9: A write issued with `eccOn` low stores the data bits of the enabled lanes and keeps their check bits.
- R10: After each checked read, `corrCount` and `uncCount` grow by the number of set bits in `corrMask` and `uncMask`. They stop at all ones (width `CNT_W`).
- R11: `clrCounts` zeroes both counters at the next edge, and it overrides any event counted at that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| eccOn | input | 1 | Protection enable, sampled with each read and write |
| addr | input | ADDR_W | Word address for read and write |
| wrEn | input | 1 | Write strobe |
| byteEn | input | LANES | Per-lane write enable |
| wrData | input | 8*LANES | Write data |
| rdEn | input | 1 | Read strobe |
| clrCounts | input | 1 | Synchronous clear of both event counters |
| rdValid | output | 1 | Read result valid, one cycle after `rdEn` |
| rdData | output | 8*LANES | Read data, repaired when protection was on |
| corrMask | output | LANES | Lanes repaired in this read |
| uncMask | output | LANES | Lanes with an uncorrectable error in this read |
| corrCount | output | CNT_W | Saturating total of corrected lanes |
| uncCount | output | CNT_W | Saturating total of uncorrectable lanes |

## Verification
The hardest situation to create from the ports is a stored word whose bits differ from what its check bits encode, and hardest of all a lone error in a check position. The bench produces both with protection-off writes, which change the data bits and keep the stale check bits. Chosen flip patterns then give one-bit, two-bit and check-position errors; the check-position case uses a three-bit data change at code positions 3, 5 and 7. Checked reads of those words, followed by enough repeated reads, drive the counters into saturation.

// File: rtl/byte_ecc_pkg.sv
package byteEccPkg;

  localparam int CODE_W = 13;
  localparam int BYTE_W = 8;

  typedef struct packed {
    logic memWrite;
    logic writeChecks;
    logic memRead;
    logic readChecked;
    logic resultValid;
    logic resultChecked;
  } ctlStrobe_t;

  // code position that carries data bit k
  function automatic int dataPos(input int k);
    case (k)
      0: return 3;
      1: return 5;
      2: return 6;
      3: return 7;
      4: return 9;
      5: return 10;
      6: return 11;
      default: return 12;
    endcase
  endfunction

  function automatic logic isCheckPos(input int j);
    return (j == 0) || (j == 1) || (j == 2) || (j == 4) || (j == 8);
  endfunction

  function automatic logic [CODE_W-1:0] encodeByte(input logic [BYTE_W-1:0] d);
    logic [CODE_W-1:0] cw;
    logic [3:0] syn;
    cw  = '0;
    syn = '0;
    for (int k = 0; k < BYTE_W; k++) cw[dataPos(k)] = d[k];
    for (int i = 1; i < CODE_W; i++) if (cw[i]) syn ^= 4'(i);
    cw[1] = syn[0];
    cw[2] = syn[1];
    cw[4] = syn[2];
    cw[8] = syn[3];
    cw[0] = ^cw[CODE_W-1:1];
    return cw;
  endfunction

  function automatic logic [BYTE_W-1:0] extractByte(input logic [CODE_W-1:0] cw);
    logic [BYTE_W-1:0] d;
    for (int k = 0; k < BYTE_W; k++) d[k] = cw[dataPos(k)];
    return d;
  endfunction

endpackage

// File: rtl/byte_ecc_decoder.sv
module byteEccDecoder
  import byteEccPkg::*;
(
  input  logic [CODE_W-1:0] codeIn,
  output logic [BYTE_W-1:0] dataOut,
  output logic              corrected,
  output logic              uncorrectable
);

  logic [3:0]        syndrome;
  logic              parityErr;
  logic [CODE_W-1:0] fixedCode;

  always_comb begin
    syndrome = '0;
    for (int i = 1; i < CODE_W; i++) if (codeIn[i]) syndrome ^= 4'(i);
    parityErr     = ^codeIn;
    fixedCode     = codeIn;
    corrected     = 1'b0;
    uncorrectable = 1'b0;
    if (parityErr) begin
      if (syndrome == 4'd0) begin
        corrected = 1'b1;                 // overall parity bit itself
      end else if (int'(syndrome) < CODE_W) begin
        fixedCode[syndrome] = ~codeIn[syndrome];
        corrected = 1'b1;
      end else begin
        uncorrectable = 1'b1;             // syndrome outside the codeword
      end
    end else if (syndrome != 4'd0) begin
      uncorrectable = 1'b1;               // even number of flips
    end
    dataOut = uncorrectable ? extractByte(codeIn) : extractByte(fixedCode);
  end

endmodule

// File: rtl/byte_ecc_ctrl.sv
module byteEccCtrl
  import byteEccPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       eccOn,
  input  logic       wrEn,
  input  logic       rdEn,
  output ctlStrobe_t strobes
);

  logic validQ;
  logic checkedQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validQ   <= 1'b0;
      checkedQ <= 1'b0;
    end else begin
      validQ   <= rdEn;
      checkedQ <= rdEn & eccOn;
    end
  end

  always_comb begin
    strobes.memWrite      = wrEn;
    strobes.writeChecks   = eccOn;
    strobes.memRead       = rdEn;
    strobes.readChecked   = eccOn;
    strobes.resultValid   = validQ;
    strobes.resultChecked = checkedQ;
  end

endmodule

// File: rtl/byte_ecc_datapath.sv
module byteEccDatapath
  import byteEccPkg::*;
#(
  parameter int LANES  = 4,
  parameter int ADDR_W = 4,
  parameter int CNT_W  = 16
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  ctlStrobe_t              strobes,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES-1:0]        byteEn,
  input  logic [LANES*BYTE_W-1:0] wrData,
  input  logic                    clrCounts,
  output logic [LANES*BYTE_W-1:0] rdData,
  output logic [LANES-1:0]        corrMask,
  output logic [LANES-1:0]        uncMask,
  output logic [CNT_W-1:0]        corrCount,
  output logic [CNT_W-1:0]        uncCount
);

  localparam int DEPTH   = 1 << ADDR_W;
  localparam int STORE_W = LANES * CODE_W;
  localparam int SUM_W   = $clog2(LANES + 1);

  logic [STORE_W-1:0] mem [DEPTH];
  logic [STORE_W-1:0] wrBits;
  logic [STORE_W-1:0] wrMask;
  logic [STORE_W-1:0] rdWord;
  logic [LANES-1:0]   laneCorr;
  logic [LANES-1:0]   laneUnc;

  // column j*LANES+b holds bit j of lane b: neighbours in a codeword are LANES apart
  for (genvar b = 0; b < LANES; b++) begin : gLane
    logic [CODE_W-1:0] encCode;
    logic [CODE_W-1:0] rdCode;
    logic [BYTE_W-1:0] fixedByte;

    assign encCode = encodeByte(wrData[b*BYTE_W +: BYTE_W]);

    for (genvar j = 0; j < CODE_W; j++) begin : gBit
      assign wrBits[j*LANES + b] = encCode[j];
      assign wrMask[j*LANES + b] = byteEn[b] & (strobes.writeChecks | !isCheckPos(j));
      assign rdCode[j]           = rdWord[j*LANES + b];
    end

    byteEccDecoder uDec (
      .codeIn       (rdCode),
      .dataOut      (fixedByte),
      .corrected    (laneCorr[b]),
      .uncorrectable(laneUnc[b])
    );

    assign rdData[b*BYTE_W +: BYTE_W] = strobes.resultChecked ? fixedByte : extractByte(rdCode);
    assign corrMask[b] = strobes.resultValid & strobes.resultChecked & laneCorr[b];
    assign uncMask[b]  = strobes.resultValid & strobes.resultChecked & laneUnc[b];
  end

  always_ff @(posedge clk) begin
    if (strobes.memWrite) begin
      for (int i = 0; i < STORE_W; i++) begin
        if (wrMask[i]) mem[addr][i] <= wrBits[i];
      end
    end
    if (strobes.memRead) rdWord <= mem[addr];
  end

  // saturating event counters
  logic [SUM_W-1:0] corrAdd;
  logic [SUM_W-1:0] uncAdd;
  logic [CNT_W:0]   corrSum;
  logic [CNT_W:0]   uncSum;

  always_comb begin
    corrAdd = '0;
    uncAdd  = '0;
    for (int b = 0; b < LANES; b++) begin
      corrAdd += SUM_W'(corrMask[b]);
      uncAdd  += SUM_W'(uncMask[b]);
    end
    corrSum = {1'b0, corrCount} + (CNT_W+1)'(corrAdd);
    uncSum  = {1'b0, uncCount} + (CNT_W+1)'(uncAdd);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      corrCount <= '0;
      uncCount  <= '0;
    end else if (clrCounts) begin
      corrCount <= '0;
      uncCount  <= '0;
    end else begin
      corrCount <= corrSum[CNT_W] ? '1 : corrSum[CNT_W-1:0];
      uncCount  <= uncSum[CNT_W]  ? '1 : uncSum[CNT_W-1:0];
    end
  end

endmodule

// File: rtl/byteEccMem.sv
module byteEccMem
  import byteEccPkg::*;
#(
  parameter int LANES  = 4,
  parameter int ADDR_W = 4,
  parameter int CNT_W  = 16
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    eccOn,
  input  logic [ADDR_W-1:0]       addr,
  input  logic                    wrEn,
  input  logic [LANES-1:0]        byteEn,
  input  logic [LANES*8-1:0]      wrData,
  input  logic                    rdEn,
  input  logic                    clrCounts,
  output logic                    rdValid,
  output logic [LANES*8-1:0]      rdData,
  output logic [LANES-1:0]        corrMask,
  output logic [LANES-1:0]        uncMask,
  output logic [CNT_W-1:0]        corrCount,
  output logic [CNT_W-1:0]        uncCount
);

  ctlStrobe_t strobes;

  byteEccCtrl uCtrl (
    .clk    (clk),
    .rstN   (rstN),
    .eccOn  (eccOn),
    .wrEn   (wrEn),
    .rdEn   (rdEn),
    .strobes(strobes)
  );

  byteEccDatapath #(.LANES(LANES), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) uPath (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .addr     (addr),
    .byteEn   (byteEn),
    .wrData   (wrData),
    .clrCounts(clrCounts),
    .rdData   (rdData),
    .corrMask (corrMask),
    .uncMask  (uncMask),
    .corrCount(corrCount),
    .uncCount (uncCount)
  );

  assign rdValid = strobes.resultValid;

endmodule

// File: rtl/byteEccMem_checker.sv
module byteEccMemChecker #(
  parameter int LANES = 4,
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             eccOn,
  input logic             rdEn,
  input logic             clrCounts,
  input logic             rdValid,
  input logic [LANES-1:0] corrMask,
  input logic [LANES-1:0] uncMask,
  input logic [CNT_W-1:0] corrCount,
  input logic [CNT_W-1:0] uncCount
);

  // R2: result appears exactly one cycle after the request
  assert_read_valid_R2: assert property (@(posedge clk) disable iff (!rstN)
    rdEn |=> rdValid);
  assert_no_spurious_valid_R2: assert property (@(posedge clk) disable iff (!rstN)
    !rdEn |=> !rdValid);

  // R6: a lane is never both repaired and uncorrectable
  assert_masks_disjoint_R6: assert property (@(posedge clk) disable iff (!rstN)
    (corrMask & uncMask) == '0);

  // R8: unprotected reads raise no flags
  assert_raw_read_quiet_R8: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && !eccOn) |=> (corrMask == '0 && uncMask == '0));

  // R10: counters never move backwards without a clear, and hold at the top
  assert_corr_monotone_R10: assert property (@(posedge clk) disable iff (!rstN)
    !clrCounts |=> corrCount >= $past(corrCount));
  assert_unc_monotone_R10: assert property (@(posedge clk) disable iff (!rstN)
    !clrCounts |=> uncCount >= $past(uncCount));
  assert_corr_saturate_R10: assert property (@(posedge clk) disable iff (!rstN)
    (corrCount == '1 && !clrCounts) |=> corrCount == '1);

  // R11: clear wins over any event at the same edge
  assert_clear_zeroes_R11: assert property (@(posedge clk) disable iff (!rstN)
    clrCounts |=> (corrCount == '0 && uncCount == '0));

endmodule

bind byteEccMem byteEccMemChecker #(.LANES(LANES), .CNT_W(CNT_W)) uChecker (
  .clk      (clk),
  .rstN     (rstN),
  .eccOn    (eccOn),
  .rdEn     (rdEn),
  .clrCounts(clrCounts),
  .rdValid  (rdValid),
  .corrMask (corrMask),
  .uncMask  (uncMask),
  .corrCount(corrCount),
  .uncCount (uncCount)
);

// File: tb/byteEccMem_test.sv
module byteEccMem_test;

  localparam int CW = 6;
  localparam int AW = 4;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          eccOn = 1'b1;
  logic [AW-1:0] addr = '0;
  logic          wrEn = 1'b0;
  logic [3:0]    byteEn = '0;
  logic [31:0]   wrData = '0;
  logic          rdEn = 1'b0;
  logic          clrCounts = 1'b0;
  logic          rdValid;
  logic [31:0]   rdData;
  logic [3:0]    corrMask;
  logic [3:0]    uncMask;
  logic [CW-1:0] corrCount;
  logic [CW-1:0] uncCount;

  always #10 clk = ~clk;   // 50 MHz

  byteEccMem #(.LANES(4), .ADDR_W(AW), .CNT_W(CW)) uut (.*);

  typedef struct {
    logic [31:0] data;
    logic [3:0]  corr;
    logic [3:0]  unc;
    string       tag;
  } expItem_t;

  expItem_t    sbQueue[$];
  int          checks = 0;
  int          errors = 0;
  logic [31:0] storedData [16];
  logic [31:0] codedData  [16];
  int          expCorrCnt = 0;
  int          expUncCnt  = 0;
  localparam int CMAX = (1 << CW) - 1;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // expected result from the deliberately chosen difference patterns
  function automatic void predict(input logic [31:0] st, input logic [31:0] cd,
                                  output logic [31:0] d, output logic [3:0] c,
                                  output logic [3:0] u);
    d = st; c = '0; u = '0;
    for (int b = 0; b < 4; b++) begin
      logic [7:0] diff;
      diff = st[b*8 +: 8] ^ cd[b*8 +: 8];
      if (diff == 8'h00) begin
      end else if (diff == 8'h0B) begin
        c[b] = 1'b1;                       // lone check-position error
      end else if ($countones(diff) == 1) begin
        c[b] = 1'b1;
        d[b*8 +: 8] = cd[b*8 +: 8];
      end else begin
        u[b] = 1'b1;
      end
    end
  endfunction

  task automatic doWrite(input int a, input logic [3:0] be, input logic [31:0] d,
                         input logic on);
    @(negedge clk);
    addr = AW'(a); byteEn = be; wrData = d; eccOn = on; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0; eccOn = 1'b1;
    for (int b = 0; b < 4; b++) begin
      if (be[b]) begin
        storedData[a][b*8 +: 8] = d[b*8 +: 8];
        if (on) codedData[a][b*8 +: 8] = d[b*8 +: 8];
      end
    end
  endtask

  // returns at the negedge where the result is visible; rdEn already low
  task automatic doRead(input int a, input logic on, input string tag);
    expItem_t it;
    @(negedge clk);
    if (on) begin
      predict(storedData[a], codedData[a], it.data, it.corr, it.unc);
      expCorrCnt = (expCorrCnt + $countones(it.corr) > CMAX) ? CMAX : expCorrCnt + $countones(it.corr);
      expUncCnt  = (expUncCnt + $countones(it.unc) > CMAX) ? CMAX : expUncCnt + $countones(it.unc);
    end else begin
      it.data = storedData[a]; it.corr = '0; it.unc = '0;
    end
    it.tag = tag;
    sbQueue.push_back(it);
    addr = AW'(a); eccOn = on; rdEn = 1'b1;
    @(negedge clk);
    rdEn = 1'b0; eccOn = 1'b1;
  endtask

  // monitor: compare each result against the scoreboard head
  always @(negedge clk) begin
    if (rstN && rdValid) begin
      if (sbQueue.size() == 0) begin
        check("R2 unexpected rdValid", 32'd1, 32'd0);
      end else begin
        expItem_t e;
        e = sbQueue.pop_front();
        check({e.tag, " data"}, rdData, e.data);
        check({e.tag, " corrMask"}, {28'd0, corrMask}, {28'd0, e.corr});
        check({e.tag, " uncMask"}, {28'd0, uncMask}, {28'd0, e.unc});
      end
    end
  end

  task automatic checkCounts(input string tag);
    @(negedge clk);
    check({tag, " corrCount"}, 32'(corrCount), 32'(expCorrCnt));
    check({tag, " uncCount"}, 32'(uncCount), 32'(expUncCnt));
  endtask

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 rdValid", 32'(rdValid), 32'd0);
    check("R1 corrCount", 32'(corrCount), 32'd0);
    check("R1 uncCount", 32'(uncCount), 32'd0);
    rstN = 1'b1;
    @(negedge clk);

    // R2: clean writes and reads
    doWrite(0, 4'hF, 32'h1234_5678, 1'b1);
    doWrite(1, 4'hF, 32'hA5C3_0FF0, 1'b1);
    doRead(0, 1'b1, "R2 clean addr0");
    doRead(1, 1'b1, "R2 clean addr1");

    // R3: partial write touches one lane only
    doWrite(0, 4'b0010, 32'hFFFF_99FF, 1'b1);
    doRead(0, 1'b1, "R3 byte-enable write");

    // R4 / R9: unprotected write flips bit 0 of lane 0, checks kept
    doWrite(0, 4'b0001, 32'h0000_0079, 1'b0);
    doRead(0, 1'b1, "R4 single data flip");
    checkCounts("R10 after one repair");

    // R8: unprotected read shows raw bits, no count change
    doRead(0, 1'b0, "R8 raw read");
    checkCounts("R8 counters held");

    // R9: writing the original byte back unprotected matches old checks
    doWrite(0, 4'b0001, 32'h0000_0078, 1'b0);
    doRead(0, 1'b1, "R9 checks kept");

    // R5: one flip in every lane
    doWrite(2, 4'hF, 32'hDEAD_BEEF, 1'b1);
    doWrite(2, 4'hF, 32'hDEAD_BEEF ^ 32'h8008_0120, 1'b0);
    doRead(2, 1'b1, "R5 four lanes repaired");

    // R6: two flips in lane 1
    doWrite(3, 4'hF, 32'h0F0F_0F0F, 1'b1);
    doWrite(3, 4'b0010, 32'h0F0F_0F0F ^ 32'h0000_4200, 1'b0);
    doRead(3, 1'b1, "R6 double flip");

    // R7: data bits 0,1,3 changed -> lone error at check position 1
    doWrite(4, 4'hF, 32'h0000_00C4, 1'b1);
    doWrite(4, 4'b0001, 32'h0000_00CF, 1'b0);
    doRead(4, 1'b1, "R7 check-bit error");
    checkCounts("R10 mixed events");

    // R11: clear with no event
    @(negedge clk); clrCounts = 1'b1;
    @(negedge clk); clrCounts = 1'b0;
    expCorrCnt = 0; expUncCnt = 0;
    checkCounts("R11 cleared");

    // R11: clear at the same edge as a counted event
    doRead(2, 1'b1, "R11 read during clear");
    clrCounts = 1'b1;
    @(negedge clk); clrCounts = 1'b0;
    expCorrCnt = 0; expUncCnt = 0;
    checkCounts("R11 clear overrides event");

    // R10: saturation after many four-lane repairs
    for (int n = 0; n < 20; n++) doRead(2, 1'b1, "R10 repeat read");
    doRead(3, 1'b1, "R10 unc read");
    checkCounts("R10 saturated");

    repeat (3) @(negedge clk);
    check("R2 scoreboard drained", 32'(sbQueue.size()), 32'd0);
    finishRun();
  end

endmodule